// File: doc/BRIEF.md
# Sprite Upload Port Controller

This block is the processor-side loader for a sprite engine. It turns three byte-wide I/O strobes into write cycles on two memories. One strobe writes a selection byte, one writes an attribute byte, and one writes a pattern byte. The first memory holds the per-sprite attributes: 128 sprites with up to five bytes each. The second holds pixel patterns: 16 KB, organised as 64 patterns of 256 bytes. A fourth strobe reads a two-bit status byte, and that read clears the status.

The selection byte loads two pointers that are kept apart from then on:
- the sprite pointer, which addresses the attribute memory;
- the pattern byte address.

Attribute bytes walk through the lanes of the current sprite. The pointer moves to the next sprite after the fourth or the fifth byte, depending on an extension bit carried in the fourth byte. Pattern bytes land at consecutive addresses.

The renderer reports two events, a sprite collision and a per-line sprite overflow, as single-cycle pulses. Each pulse sets a sticky flag that software reads through the selection port.

Top module: `sprite_loader`

## Requirements
- R1: After reset, `attr_we` and `pat_we` are 0, `sel_rdata` is 0x00, the sprite pointer is 0, the attribute byte counter is 0 and the pattern address is 0.
- R2: A selection write with byte S does three things. It sets the sprite pointer to S[6:0]. It sets the pattern address to {S[5:0], S[7], 7'b0}, so bit 7 adds a 128-byte half-pattern offset. It resets the attribute byte counter to 0. Later attribute writes do not move the pattern address, and pattern writes do not move the sprite pointer.
- R3: Each pattern write produces one cycle of `pat_we`, in the cycle after the strobe. `pat_addr` equals the current pattern address and `pat_wdata` equals the byte. The pattern address then increments by one.
- R4: The pattern address is 14 bits wide and wraps from 0x3FFF to 0x0000.
- R5: An attribute write produces one cycle of `attr_we`, in the cycle after the strobe. `attr_addr` is the current sprite. `attr_wbe` bit k is set, where k is the attribute byte counter (0..4). The byte is placed in `attr_wdata[8k+7:8k]`.
- R6: When the fourth byte (k=3) has bit 6 set, the counter moves to 4, and the fifth byte is written before the sprite pointer advances. When bit 6 is clear, the same cycle also enables lane 4 (`attr_wbe` = 5'b11000) with lane 4 data 0x00, and the sprite pointer advances with the counter back at 0.
- R7: The sprite pointer advances from 127 to 0.
- R8: `sel_rdata` is {6'b0, overflow flag, collision flag}. A `ren_overflow` or `ren_collide` pulse sets its flag from the next cycle, and the flag holds until it is read.
- R9: A status read (`io_rd_sel`) returns the flags in that cycle and clears both flags from the next cycle.
- R10: A set pulse in the same cycle as a status read wins: that flag is set in the next cycle.
- R11: A selection write in the middle of a sprite's attribute sequence restarts the counter, so the next attribute byte goes to lane 0 of the newly selected sprite.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| io_wr_sel | input | 1 | Selection write strobe (highest priority) |
| io_wr_attr | input | 1 | Attribute byte write strobe (priority over pattern) |
| io_wr_pat | input | 1 | Pattern byte write strobe |
| io_rd_sel | input | 1 | Status read strobe, clears flags |
| io_wdata | input | 8 | Byte written with any write strobe |
| sel_rdata | output | 8 | Status byte {6'b0, overflow, collision} |
| ren_collide | input | 1 | Renderer collision pulse |
| ren_overflow | input | 1 | Renderer per-line overflow pulse |
| attr_we | output | 1 | Attribute memory write enable |
| attr_addr | output | 7 | Sprite being written |
| attr_wbe | output | 5 | Per-lane byte enables of the attribute word |
| attr_wdata | output | 40 | Attribute word data, lane k in bits 8k+7:8k |
| pat_we | output | 1 | Pattern memory write enable |
| pat_addr | output | 14 | Pattern memory byte address |
| pat_wdata | output | 8 | Pattern memory byte |

## Verification
The assertions check several rules on every cycle:
- a pattern strobe is followed by a write;
- back-to-back pattern writes step the address by one, modulo 16 K;
- an attribute write enables one lane, or exactly the two top lanes, and the short-form case carries a zero top lane;
- flags stay set until read, a set pulse wins over a clear, and a read with no pulse empties both flags.

The bench scenarios show the rest:
- the actual pointer values after a selection byte, including the half-pattern offset and the separation of the two pointers;
- the four-byte versus five-byte advance decided by bit 6;
- the sprite wrap from 127 to 0 and the pattern wrap at 0x3FFF;
- the restart of the byte counter by a mid-sprite selection.

// File: rtl/sprite_loader_pkg.sv
package sprite_loader_pkg;

  localparam int unsigned BYTE_W        = 8;
  // bit of the fourth attribute byte that announces a fifth byte
  localparam int unsigned EXT_FLAG_BIT  = 6;
  // bit of the selection byte that adds a half-pattern offset
  localparam int unsigned HALF_SEL_BIT  = 7;

  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_SEL  = 2'd1,
    CMD_ATTR = 2'd2,
    CMD_PAT  = 2'd3
  } cmd_e;

  typedef struct packed {
    logic line_ovf;
    logic collide;
  } flags_t;

endpackage

// File: rtl/sprite_attr_seq.sv
module sprite_attr_seq
  import sprite_loader_pkg::*;
#(
  parameter int unsigned N_SPR  = 128,
  parameter int unsigned N_ATTR = 5,
  localparam int unsigned SPR_W  = $clog2(N_SPR),
  localparam int unsigned CNT_W  = $clog2(N_ATTR),
  localparam int unsigned WORD_W = N_ATTR * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cmd_e              cmd,
  input  logic [BYTE_W-1:0] wdata,
  output logic              attr_we,
  output logic [SPR_W-1:0]  attr_addr,
  output logic [N_ATTR-1:0] attr_wbe,
  output logic [WORD_W-1:0] attr_wdata
);

  localparam int unsigned LAST_IDX = N_ATTR - 1;
  localparam int unsigned EXT_IDX  = N_ATTR - 2;

  logic [SPR_W-1:0]  spr_q, spr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              ptr_en;
  logic              we_d;
  logic [SPR_W-1:0]  addr_d;
  logic [N_ATTR-1:0] be_d;
  logic [WORD_W-1:0] data_d;
  logic              short_end;
  logic              sprite_done;

  assign short_end   = (cnt_q == CNT_W'(EXT_IDX)) && !wdata[EXT_FLAG_BIT];
  assign sprite_done = short_end || (cnt_q == CNT_W'(LAST_IDX));
  assign ptr_en      = (cmd == CMD_SEL) || (cmd == CMD_ATTR);

  always_comb begin
    spr_d  = spr_q;
    cnt_d  = cnt_q;
    we_d   = 1'b0;
    addr_d = spr_q;
    be_d   = '0;
    data_d = '0;
    case (cmd)
      CMD_SEL: begin
        spr_d = wdata[SPR_W-1:0];
        cnt_d = '0;
      end
      CMD_ATTR: begin
        we_d = 1'b1;
        for (int k = 0; k < int'(N_ATTR); k++) begin
          if (cnt_q == CNT_W'(k)) begin
            be_d[k]                = 1'b1;
            data_d[k*BYTE_W +: BYTE_W] = wdata;
          end
        end
        if (short_end) begin
          be_d[LAST_IDX] = 1'b1;
        end
        if (sprite_done) begin
          cnt_d = '0;
          spr_d = (spr_q == SPR_W'(N_SPR - 1)) ? '0 : SPR_W'(spr_q + 1'b1);
        end else begin
          cnt_d = CNT_W'(cnt_q + 1'b1);
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spr_q <= '0;
      cnt_q <= '0;
    end else if (ptr_en) begin
      spr_q <= spr_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      attr_we    <= 1'b0;
      attr_addr  <= '0;
      attr_wbe   <= '0;
      attr_wdata <= '0;
    end else begin
      attr_we    <= we_d;
      attr_addr  <= addr_d;
      attr_wbe   <= be_d;
      attr_wdata <= data_d;
    end
  end

endmodule

// File: rtl/sprite_pat_seq.sv
module sprite_pat_seq
  import sprite_loader_pkg::*;
#(
  parameter int unsigned PAT_AW = 14,
  localparam int unsigned IDX_W = PAT_AW - BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cmd_e              cmd,
  input  logic [BYTE_W-1:0] wdata,
  output logic              pat_we,
  output logic [PAT_AW-1:0] pat_addr,
  output logic [BYTE_W-1:0] pat_wdata
);

  logic [PAT_AW-1:0] ptr_q, ptr_d;
  logic              ptr_en;
  logic              we_d;
  logic [PAT_AW-1:0] addr_d;
  logic [BYTE_W-1:0] data_d;

  assign ptr_en = (cmd == CMD_SEL) || (cmd == CMD_PAT);

  always_comb begin
    ptr_d  = ptr_q;
    we_d   = 1'b0;
    addr_d = ptr_q;
    data_d = '0;
    case (cmd)
      CMD_SEL: ptr_d = {wdata[IDX_W-1:0], wdata[HALF_SEL_BIT], {(BYTE_W-1){1'b0}}};
      CMD_PAT: begin
        we_d   = 1'b1;
        data_d = wdata;
        ptr_d  = PAT_AW'(ptr_q + 1'b1);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pat_we    <= 1'b0;
      pat_addr  <= '0;
      pat_wdata <= '0;
    end else begin
      pat_we    <= we_d;
      pat_addr  <= addr_d;
      pat_wdata <= data_d;
    end
  end

endmodule

// File: rtl/sprite_status.sv
module sprite_status
  import sprite_loader_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_clr,
  input  logic              set_collide,
  input  logic              set_ovf,
  output logic [BYTE_W-1:0] status
);

  flags_t flg_q, flg_d;

  always_comb begin
    flg_d.collide  = set_collide | (flg_q.collide  & ~rd_clr);
    flg_d.line_ovf = set_ovf     | (flg_q.line_ovf & ~rd_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg_q <= '0;
    end else begin
      flg_q <= flg_d;
    end
  end

  assign status = {{(BYTE_W-2){1'b0}}, flg_q.line_ovf, flg_q.collide};

endmodule

// File: rtl/sprite_loader.sv
module sprite_loader
  import sprite_loader_pkg::*;
#(
  parameter int unsigned N_SPR  = 128,
  parameter int unsigned N_ATTR = 5,
  parameter int unsigned PAT_AW = 14,
  localparam int unsigned SPR_W  = $clog2(N_SPR),
  localparam int unsigned WORD_W = N_ATTR * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_wr_sel,
  input  logic              io_wr_attr,
  input  logic              io_wr_pat,
  input  logic              io_rd_sel,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        sel_rdata,
  input  logic              ren_collide,
  input  logic              ren_overflow,
  output logic              attr_we,
  output logic [SPR_W-1:0]  attr_addr,
  output logic [N_ATTR-1:0] attr_wbe,
  output logic [WORD_W-1:0] attr_wdata,
  output logic              pat_we,
  output logic [PAT_AW-1:0] pat_addr,
  output logic [7:0]        pat_wdata
);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  cmd_e       cmd;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  // one command per cycle: selection, then attribute, then pattern
  always_comb begin
    if (io_wr_sel)       cmd = CMD_SEL;
    else if (io_wr_attr) cmd = CMD_ATTR;
    else if (io_wr_pat)  cmd = CMD_PAT;
    else                 cmd = CMD_NONE;
  end

  sprite_attr_seq #(.N_SPR(N_SPR), .N_ATTR(N_ATTR)) u_attr (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .cmd       (cmd),
    .wdata     (io_wdata),
    .attr_we   (attr_we),
    .attr_addr (attr_addr),
    .attr_wbe  (attr_wbe),
    .attr_wdata(attr_wdata)
  );

  sprite_pat_seq #(.PAT_AW(PAT_AW)) u_pat (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .cmd      (cmd),
    .wdata    (io_wdata),
    .pat_we   (pat_we),
    .pat_addr (pat_addr),
    .pat_wdata(pat_wdata)
  );

  sprite_status u_stat (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .rd_clr     (io_rd_sel),
    .set_collide(ren_collide),
    .set_ovf    (ren_overflow),
    .status     (sel_rdata)
  );

endmodule

// File: rtl/sprite_loader_chk.sv
module sprite_loader_chk #(
  parameter int unsigned N_SPR  = 128,
  parameter int unsigned N_ATTR = 5,
  parameter int unsigned PAT_AW = 14,
  localparam int unsigned SPR_W  = $clog2(N_SPR),
  localparam int unsigned WORD_W = N_ATTR * 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              io_wr_sel,
  input logic              io_wr_attr,
  input logic              io_wr_pat,
  input logic              io_rd_sel,
  input logic [7:0]        sel_rdata,
  input logic              ren_collide,
  input logic              ren_overflow,
  input logic              attr_we,
  input logic [N_ATTR-1:0] attr_wbe,
  input logic [WORD_W-1:0] attr_wdata,
  input logic              pat_we,
  input logic [PAT_AW-1:0] pat_addr
);

  localparam int unsigned TOP = N_ATTR - 1;

  // R3: an unopposed pattern strobe produces a write next cycle
  p_pat_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    io_wr_pat && !io_wr_sel && !io_wr_attr |=> pat_we);

  // R4: consecutive pattern writes step the address by one, modulo 2^PAT_AW
  p_pat_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pat_we && $past(pat_we) |-> pat_addr == PAT_AW'($past(pat_addr) + 1'b1));

  // R5: an attribute write enables one lane or two
  p_lane_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    attr_we |-> ($countones(attr_wbe) == 1) || ($countones(attr_wbe) == 2));

  // R5: no attribute write without a strobe in the cycle before
  p_attr_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !io_wr_attr |=> !attr_we);

  // R6: the two-lane form is the short end with a zero top lane
  p_short_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    attr_we && attr_wbe[TOP] && attr_wbe[TOP-1] |->
      attr_wdata[TOP*8 +: 8] == 8'h00 && !attr_wdata[(TOP-1)*8 + 6]);

  // R8: a flag stays set until it is read
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sel_rdata[0] && !io_rd_sel |=> sel_rdata[0]);

  // R9: a read with no set pulse empties both flags
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    io_rd_sel && !ren_collide && !ren_overflow |=> sel_rdata[1:0] == 2'b00);

  // R10: set pulses win over a clear in the same cycle
  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ren_collide |=> sel_rdata[0]);
  p_ovf_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ren_overflow |=> sel_rdata[1]);

endmodule

bind sprite_loader sprite_loader_chk #(
  .N_SPR(N_SPR), .N_ATTR(N_ATTR), .PAT_AW(PAT_AW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .io_wr_sel(io_wr_sel), .io_wr_attr(io_wr_attr),
  .io_wr_pat(io_wr_pat), .io_rd_sel(io_rd_sel), .sel_rdata(sel_rdata),
  .ren_collide(ren_collide), .ren_overflow(ren_overflow), .attr_we(attr_we),
  .attr_wbe(attr_wbe), .attr_wdata(attr_wdata), .pat_we(pat_we),
  .pat_addr(pat_addr)
);

// File: tb/sprite_loader_test.sv
`timescale 1ns/1ps
module sprite_loader_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_wr_sel = 1'b0, io_wr_attr = 1'b0, io_wr_pat = 1'b0, io_rd_sel = 1'b0;
  logic [7:0]  io_wdata = 8'h00;
  logic [7:0]  sel_rdata;
  logic        ren_collide = 1'b0, ren_overflow = 1'b0;
  logic        attr_we;
  logic [6:0]  attr_addr;
  logic [4:0]  attr_wbe;
  logic [39:0] attr_wdata;
  logic        pat_we;
  logic [13:0] pat_addr;
  logic [7:0]  pat_wdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sprite_loader uut (
    .clk(clk), .rst_n(rst_n), .io_wr_sel(io_wr_sel), .io_wr_attr(io_wr_attr),
    .io_wr_pat(io_wr_pat), .io_rd_sel(io_rd_sel), .io_wdata(io_wdata),
    .sel_rdata(sel_rdata), .ren_collide(ren_collide), .ren_overflow(ren_overflow),
    .attr_we(attr_we), .attr_addr(attr_addr), .attr_wbe(attr_wbe),
    .attr_wdata(attr_wdata), .pat_we(pat_we), .pat_addr(pat_addr),
    .pat_wdata(pat_wdata)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_sel(input logic [7:0] d);
    @(negedge clk); io_wr_sel = 1'b1; io_wdata = d;
    @(negedge clk); io_wr_sel = 1'b0;
  endtask

  // write one attribute byte and check the write it causes
  task automatic attr_byte(input logic [7:0] d, input logic [6:0] ea,
                           input logic [4:0] ebe, input string req);
    @(negedge clk); io_wr_attr = 1'b1; io_wdata = d;
    @(negedge clk); io_wr_attr = 1'b0;
    chk(attr_we == 1'b1, req, "attr_we", 64'(attr_we), 64'd1);
    chk(attr_addr == ea, req, "attr_addr", 64'(attr_addr), 64'(ea));
    chk(attr_wbe == ebe, req, "attr_wbe", 64'(attr_wbe), 64'(ebe));
    for (int k = 0; k < 5; k++) begin
      if (ebe[k]) begin
        logic [7:0] el;
        el = (k == 4 && ebe[3]) ? 8'h00 : d;
        chk(attr_wdata[8*k +: 8] == el, req, "attr lane", 64'(attr_wdata[8*k +: 8]), 64'(el));
      end
    end
  endtask

  task automatic pat_byte(input logic [7:0] d, input logic [13:0] ea, input string req);
    @(negedge clk); io_wr_pat = 1'b1; io_wdata = d;
    @(negedge clk); io_wr_pat = 1'b0;
    chk(pat_we == 1'b1, req, "pat_we", 64'(pat_we), 64'd1);
    chk(pat_addr == ea, req, "pat_addr", 64'(pat_addr), 64'(ea));
    chk(pat_wdata == d, req, "pat_wdata", 64'(pat_wdata), 64'(d));
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(attr_we == 1'b0, "R1", "attr_we", 64'(attr_we), 64'd0);
    chk(pat_we == 1'b0, "R1", "pat_we", 64'(pat_we), 64'd0);
    chk(sel_rdata == 8'h00, "R1", "sel_rdata", 64'(sel_rdata), 64'd0);
    attr_byte(8'h5A, 7'd0, 5'b00001, "R1");
    pat_byte(8'hA5, 14'd0, "R1");
  endtask

  task automatic t_select_split;
    do_sel(8'hC5);                       // sprite 0x45, pattern 5 + half
    pat_byte(8'h10, 14'h0580, "R2");
    attr_byte(8'h20, 7'h45, 5'b00001, "R2");
    pat_byte(8'h11, 14'h0581, "R2");
    attr_byte(8'h21, 7'h45, 5'b00010, "R2");
  endtask

  task automatic t_pattern;
    do_sel(8'h03);
    for (int i = 0; i < 3; i++) pat_byte(8'(8'h30 + i), 14'(14'h0300 + i), "R3");
    @(negedge clk);
    chk(pat_we == 1'b0, "R3", "pat_we single cycle", 64'(pat_we), 64'd0);
  endtask

  task automatic t_pat_wrap;
    do_sel(8'hBF);                       // pattern 63 + half = 0x3F80
    for (int i = 0; i < 128; i++) pat_byte(8'(i), 14'(14'h3F80 + i), "R4");
    pat_byte(8'hEE, 14'h0000, "R4");
  endtask

  task automatic t_attr_long;
    do_sel(8'h05);
    attr_byte(8'h11, 7'd5, 5'b00001, "R5");
    attr_byte(8'h22, 7'd5, 5'b00010, "R5");
    attr_byte(8'h33, 7'd5, 5'b00100, "R5");
    attr_byte(8'h44, 7'd5, 5'b01000, "R6");   // bit 6 set: fifth follows
    attr_byte(8'h55, 7'd5, 5'b10000, "R6");
    attr_byte(8'h66, 7'd6, 5'b00001, "R6");
  endtask

  task automatic t_attr_short;
    do_sel(8'h0A);
    attr_byte(8'hA1, 7'h0A, 5'b00001, "R6");
    attr_byte(8'hA2, 7'h0A, 5'b00010, "R6");
    attr_byte(8'hA3, 7'h0A, 5'b00100, "R6");
    attr_byte(8'h83, 7'h0A, 5'b11000, "R6");  // bit 6 clear: lane 4 zeroed
    attr_byte(8'hB0, 7'h0B, 5'b00001, "R6");
  endtask

  task automatic t_spr_wrap;
    do_sel(8'h7F);
    attr_byte(8'h01, 7'h7F, 5'b00001, "R7");
    attr_byte(8'h02, 7'h7F, 5'b00010, "R7");
    attr_byte(8'h03, 7'h7F, 5'b00100, "R7");
    attr_byte(8'h00, 7'h7F, 5'b11000, "R7");
    attr_byte(8'h09, 7'h00, 5'b00001, "R7");
  endtask

  task automatic t_sel_restart;
    do_sel(8'h20);
    attr_byte(8'hC1, 7'h20, 5'b00001, "R11");
    attr_byte(8'hC2, 7'h20, 5'b00010, "R11");
    do_sel(8'h21);
    attr_byte(8'hC3, 7'h21, 5'b00001, "R11");
  endtask

  task automatic t_flags;
    @(negedge clk); ren_collide = 1'b1;
    @(negedge clk); ren_collide = 1'b0;
    chk(sel_rdata == 8'h01, "R8", "collision flag", 64'(sel_rdata), 64'h01);
    @(negedge clk); ren_overflow = 1'b1;
    @(negedge clk); ren_overflow = 1'b0;
    repeat (3) @(negedge clk);
    chk(sel_rdata == 8'h03, "R8", "both flags held", 64'(sel_rdata), 64'h03);
    io_rd_sel = 1'b1;
    chk(sel_rdata == 8'h03, "R9", "read value", 64'(sel_rdata), 64'h03);
    @(negedge clk); io_rd_sel = 1'b0;
    chk(sel_rdata == 8'h00, "R9", "cleared by read", 64'(sel_rdata), 64'h00);
  endtask

  task automatic t_set_wins;
    @(negedge clk); ren_collide = 1'b1;
    @(negedge clk); ren_collide = 1'b0;
    io_rd_sel = 1'b1; ren_overflow = 1'b1;
    @(negedge clk); io_rd_sel = 1'b0; ren_overflow = 1'b0;
    chk(sel_rdata == 8'h02, "R10", "set beats clear", 64'(sel_rdata), 64'h02);
    @(negedge clk); io_rd_sel = 1'b1; ren_collide = 1'b1;
    @(negedge clk); io_rd_sel = 1'b0; ren_collide = 1'b0;
    chk(sel_rdata == 8'h01, "R10", "collide beats clear", 64'(sel_rdata), 64'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_select_split;
    t_pattern;
    t_pat_wrap;
    t_attr_long;
    t_attr_short;
    t_spr_wrap;
    t_sel_restart;
    t_flags;
    t_set_wins;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule